// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a bank of flip-flops placed between two pieces of logic under test. A two-bit mode input sets how the bank updates on each rising clock edge. In pass-through mode it is a plain parallel register. In scan mode it is a serial shift chain. In pattern mode it is an internal-XOR (Galois) linear feedback shift register that produces pseudo-random stimulus. In signature mode it is a multiple-input signature register that folds one parallel response word per clock into its state.

The feedback taps come from a parameter and are fixed at elaboration. A seed-load input copies the parallel input into the bank in any mode. This lets a test sequence start pattern generation or compaction from a known value. The bank drives its state on the parallel output at all times, and its top stage on the scan output.

The block has no valid/ready handshake. It takes one word on every clock, so there is no back-pressure to manage.

Top module: `bilbo_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every stage to 0. It overrides seed load and mode.
- R2: With mode 2'b00 (pass-through) and no seed load, the state after the edge equals `par_in` sampled at that edge.
- R3: With mode 2'b01 (scan) and no seed load, the state shifts one place toward the top each edge. Bit 0 takes `scan_in`, `scan_out` always shows bit WIDTH-1, and `par_in` has no effect on the state.
- R4: With mode 2'b10 (pattern) and a nonzero state, the next state is the current state multiplied by x modulo the feedback polynomial. Bit i takes bit i-1. Bit 0 takes the old top bit. The old top bit is also XORed into every bit i for which TAPS[i] is 1 (default TAPS = 8'h1D, i.e. x^8+x^4+x^3+x^2+1).
- R5: With mode 2'b10 and an all-zero state, the next state is 1 (only bit 0 set). Pattern mode never leaves the state at zero.
- R6: With the default primitive taps and a nonzero start, pattern mode visits 255 distinct nonzero states and returns to the start value on the 255th step.
- R7: With mode 2'b11 (signature), each bit i takes the R4 pattern-mode value XORed with `par_in[i]`.
- R8: `seed_load` high (without reset) loads `par_in` into the state in any mode. It takes precedence over the mode.
- R9: In signature mode, an error in input bit j at one edge followed by an error in bit j+1 at the next edge yields the same signature as the error-free run when stage j+1 has no tap (j = 5 with default taps). A single error yields a different signature.
- R10: The mode is sampled at each clock edge, so a change of mode governs the very next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 pass, 01 scan, 10 pattern, 11 signature |
| seed_load | input | 1 | Load `par_in` into the state |
| par_in | input | WIDTH | Parallel data / response word / seed |
| scan_in | input | 1 | Serial input into bit 0 in scan mode |
| par_out | output | WIDTH | Current state |
| scan_out | output | 1 | Current top bit (WIDTH-1) |

## Verification
The bench enters pattern mode from an all-zero state to confirm the forced seed of 1. A design that lacked this would lock at zero and send a constant pattern to the logic under test. It walks the full 255-state cycle and checks that no state repeats early. A wrong tap or a wrong shift direction would show up as a short cycle or a repeat.

In scan mode it toggles `par_in` to catch a mux that leaks parallel data into the chain. It places seed loads in every mode to expose a wrong priority. It injects paired errors on bits 5 and 6 in consecutive cycles and expects the signature to cancel, and a single error that must be caught. A design with a tap on the wrong stage, or with the response bits added in the wrong place, would break one of those two outcomes.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_SCAN = 2'b01,
    MODE_GEN  = 2'b10,
    MODE_SIG  = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_galois_step.sv
// One step of an internal-XOR shift register; inject_i is XORed per stage.
module bilbo_galois_step #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'h1D
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] inject_i,
  output logic [WIDTH-1:0] next_o
);
  logic fb;
  assign fb = state_i[WIDTH-1];

  assign next_o[0] = fb ^ inject_i[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    if (TAPS[i]) begin : g_tap
      assign next_o[i] = state_i[i-1] ^ fb ^ inject_i[i];
    end else begin : g_plain
      assign next_o[i] = state_i[i-1] ^ inject_i[i];
    end
  end
endmodule

// File: rtl/bilbo_shift_step.sv
// Serial shift toward the top stage.
module bilbo_shift_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             serial_i,
  output logic [WIDTH-1:0] next_o
);
  assign next_o = {state_i[WIDTH-2:0], serial_i};
endmodule

// File: rtl/bilbo_next_sel.sv
// Chooses the next state from the candidate paths.
module bilbo_next_sel
  import bilbo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bilbo_mode_e      mode_i,
  input  logic             seed_load_i,
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic [WIDTH-1:0] shift_nxt_i,
  input  logic [WIDTH-1:0] galois_nxt_i,
  output logic [WIDTH-1:0] next_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    if (seed_load_i) begin
      next_o = par_i;
    end else begin
      unique case (mode_i)
        MODE_PASS: next_o = par_i;
        MODE_SCAN: next_o = shift_nxt_i;
        MODE_GEN:  next_o = (state_i == '0) ? ONE : galois_nxt_i;
        MODE_SIG:  next_o = galois_nxt_i;
        default:   next_o = state_i;
      endcase
    end
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'h1D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  bilbo_mode_e      mode_e;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] inject;
  logic [WIDTH-1:0] shift_nxt;
  logic [WIDTH-1:0] galois_nxt;
  logic [WIDTH-1:0] state_d;

  assign mode_e = bilbo_mode_e'(mode);
  assign inject = (mode_e == MODE_SIG) ? par_in : '0;

  bilbo_shift_step #(.WIDTH(WIDTH)) u_shift (
    .state_i (state_q),
    .serial_i(scan_in),
    .next_o  (shift_nxt)
  );

  bilbo_galois_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_galois (
    .state_i (state_q),
    .inject_i(inject),
    .next_o  (galois_nxt)
  );

  bilbo_next_sel #(.WIDTH(WIDTH)) u_sel (
    .mode_i      (mode_e),
    .seed_load_i (seed_load),
    .state_i     (state_q),
    .par_i       (par_in),
    .shift_nxt_i (shift_nxt),
    .galois_nxt_i(galois_nxt),
    .next_o      (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign par_out  = state_q;
  assign scan_out = state_q[WIDTH-1];

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> par_out == $past(par_in)); // R8
  AST_PASS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && mode == 2'b00) |=> par_out == $past(par_in)); // R2
  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && mode == 2'b01) |=> par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)}); // R3
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && mode == 2'b10) |=> par_out != '0); // R5
  AST_GEN_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && mode == 2'b10 && par_out == '0) |=> par_out == ONE); // R5
  AST_SCAN_OUT_TOP: assert property (@(posedge clk) disable iff (rst)
    scan_out == par_out[WIDTH-1]); // R3
endmodule

// File: tb/sim_bilbo_reg.sv
module sim_bilbo_reg;
  localparam int W = 8;
  localparam logic [W-1:0] POLY_LOW = 8'h1D;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic         seed_load;
  logic [W-1:0] par_in;
  logic         scan_in;
  logic [W-1:0] par_out;
  logic         scan_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] ref_state;

  always #2 clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAPS(POLY_LOW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .seed_load(seed_load),
    .par_in(par_in), .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  // Reference: polynomial multiply by x with reduction.
  function automatic logic [W-1:0] times_x(input logic [W-1:0] s);
    logic [W-1:0] r;
    r = s << 1;
    if (s[W-1]) r = r ^ POLY_LOW;
    return r;
  endfunction

  function automatic logic [W-1:0] ref_next(input logic r, input logic [1:0] m,
      input logic sl, input logic [W-1:0] p, input logic si, input logic [W-1:0] s);
    if (r) return '0;
    if (sl) return p;
    case (m)
      2'b00: return p;
      2'b01: return {s[W-2:0], si};
      2'b10: return (s == '0) ? 8'h01 : times_x(s);
      default: return times_x(s) ^ p;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] m, input logic sl,
      input logic [W-1:0] p, input logic si, input string tag);
    @(negedge clk);
    rst = r; mode = m; seed_load = sl; par_in = p; scan_in = si;
    ref_state = ref_next(r, m, sl, p, si, ref_state);
    @(posedge clk);
    #1;
    exp_q.push_back(ref_state);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares state and scan output against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, par_out, e);
        check({t, " scan_out"}, {7'd0, scan_out}, {7'd0, e[W-1]});
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] sig_clean, sig_pair, sig_single, start;
    bit seen[256];
    bit dup;
    ref_state = '0;
    rst = 1; mode = 0; seed_load = 0; par_in = 0; scan_in = 0;
    // R1: reset with everything else active
    step(1, 2'b11, 1, 8'hFF, 1, "R1 reset");
    step(0, 2'b00, 0, 8'h3C, 0, "R2 pass");
    step(0, 2'b00, 0, 8'hC3, 1, "R2 pass");
    step(1, 2'b00, 0, 8'h77, 0, "R1 reset mid-run");
    // R3: scan, par_in toggles and must not matter
    for (int i = 0; i < 10; i++)
      step(0, 2'b01, 0, (i % 2) ? 8'hFF : 8'hAA, i[0] ^ i[2], "R3 scan");
    // R5: pattern mode from zero
    step(1, 2'b00, 0, 8'h00, 0, "R1 reset");
    step(0, 2'b10, 0, 8'hF0, 0, "R5 zero forces seed");
    step(0, 2'b10, 0, 8'hF0, 0, "R4 gen");
    // R8: seed load in each mode
    step(0, 2'b10, 1, 8'h80, 0, "R8 seed in gen");
    step(0, 2'b10, 0, 8'h00, 0, "R4 gen with top bit set");
    step(0, 2'b01, 1, 8'h5A, 1, "R8 seed in scan");
    step(0, 2'b11, 1, 8'h96, 0, "R8 seed in sig");
    step(0, 2'b11, 0, 8'h0F, 0, "R7 sig");
    // R10: mode changes each edge
    step(0, 2'b00, 0, 8'h12, 0, "R10 pass");
    step(0, 2'b11, 0, 8'h81, 0, "R10 sig");
    step(0, 2'b01, 0, 8'h00, 1, "R10 scan");
    step(0, 2'b10, 0, 8'h00, 0, "R10 gen");
    // R6: full cycle
    step(0, 2'b00, 1, 8'h01, 0, "R8 seed");
    start = par_out;
    foreach (seen[i]) seen[i] = 0;
    seen[start] = 1;
    dup = 0;
    for (int i = 0; i < 255; i++) begin
      step(0, 2'b10, 0, 8'h00, 0, "R6 gen");
      if (i < 254) begin
        if (seen[par_out] || par_out == 0) dup = 1;
        seen[par_out] = 1;
      end
    end
    check("R6 no early repeat", {7'd0, dup}, 8'd0);
    check("R6 period 255", par_out, start);
    // R9: aliasing
    step(0, 2'b00, 1, 8'hA5, 0, "R8 seed");
    step(0, 2'b11, 0, 8'h11, 0, "R7 sig");
    step(0, 2'b11, 0, 8'h22, 0, "R7 sig");
    step(0, 2'b11, 0, 8'h44, 0, "R7 sig");
    sig_clean = par_out;
    step(0, 2'b00, 1, 8'hA5, 0, "R8 seed");
    step(0, 2'b11, 0, 8'h11 ^ 8'h20, 0, "R9 err bit5");
    step(0, 2'b11, 0, 8'h22 ^ 8'h40, 0, "R9 err bit6");
    step(0, 2'b11, 0, 8'h44, 0, "R7 sig");
    sig_pair = par_out;
    step(0, 2'b00, 1, 8'hA5, 0, "R8 seed");
    step(0, 2'b11, 0, 8'h11 ^ 8'h20, 0, "R9 single err");
    step(0, 2'b11, 0, 8'h22, 0, "R7 sig");
    step(0, 2'b11, 0, 8'h44, 0, "R7 sig");
    sig_single = par_out;
    check("R9 paired errors alias", sig_pair, sig_clean);
    check("R9 single error caught", {7'd0, sig_single != sig_clean}, 8'd1);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule